// File: doc/BRIEF.md
# Load Queue with Memory-Order Violation Scan

This block keeps the in-flight loads of an out-of-order core in a circular queue, oldest at the head and youngest at the tail. Each load is allocated in program order with a 16-bit sequence number. At allocation it also records where the store queue's tail stood, or that the store queue was empty. When the load later executes, the execute stage writes its effective address into the slot the load was given.

When a store resolves its address, the store side presents the load-queue position it captured when the store itself was allocated. The block then walks the loads from that position up to the current tail, one slot per clock. It looks for a load that has already executed and whose address falls in the same 256-byte region as the store. The first such load is latched as the violator and announced with a one-cycle pulse. It stays latched until the consumer acknowledges it.

Commit retires loads from the head. A squash walks back from the youngest load and drops every load younger than a given sequence number.

Top module: `lq_order_check`

## Requirements
- R1: After reset the queue is empty: `count` is 0, `alloc_ready` is 1, and `st_busy`, `squash_busy`, `viol_hold` and `viol_pulse` are 0.
- R2: The ring has DEPTH+1 slots and holds at most DEPTH loads. `alloc_ready` is low when DEPTH loads are held, and an `alloc_valid` presented then changes nothing. Each accepted load takes the slot shown on `alloc_idx`, and `alloc_idx` advances by one modulo DEPTH+1.
- R3: An allocated load records `sq_tail` with its valid flag set, or a cleared flag when `sq_empty` is 1. For the oldest load these are shown on `head_sq_vld`/`head_sq_pos`, and its sequence number on `head_seq`.
- R4: An accepted store check scans slots from `st_lq_pos` up to, but not including, the current tail, one slot per clock. If the first hit is at offset j, `st_busy` is high for j+1 cycles. If k slots are scanned with no hit, it is high for k+1 cycles. If `st_lq_pos` equals the tail, no scan starts and `st_busy` stays low.
- R5: A load conflicts with the store when bits ADDR_W-1:8 of the two addresses are equal. A load that has not executed since allocation never conflicts.
- R6: The first conflicting load in scan order ends the scan. `viol_pulse` is high for exactly one cycle, `viol_idx` gives that load's slot, and later conflicting loads are not reported.
- R7: `viol_hold` and `viol_idx` stay unchanged until `viol_ack`. A store check presented while `viol_hold` is 1 is ignored: it produces no scan and no pulse.
- R8: While `commit_valid` is high and no squash is running, one load per cycle retires from the head, provided the queue is not empty and its sequence number is at or below `commit_seq`.
- R9: A `squash_valid` pulse starts a backward walk from the youngest load. The walk removes one load per cycle while the queue is not empty and that load's sequence number exceeds `squash_seq`. `squash_busy` is high for (removed+1) cycles and `alloc_ready` is low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| sq_tail | input | SQ_IDX_W | Current store-queue tail |
| sq_empty | input | 1 | Store queue holds no stores |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_idx | output | IDX_W | Slot the next load receives (tail) |
| exec_valid | input | 1 | Write an executed load's address |
| exec_idx | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Effective address of the executed load |
| st_valid | input | 1 | Start an ordering check for a store |
| st_lq_pos | input | IDX_W | Load-queue tail captured by the store |
| st_addr | input | ADDR_W | Store effective address |
| st_busy | output | 1 | Scan in progress |
| viol_pulse | output | 1 | One-cycle violation report |
| viol_idx | output | IDX_W | Slot of the latched violator |
| viol_hold | output | 1 | A violator is latched |
| viol_ack | input | 1 | Read out and clear the violator |
| commit_valid | input | 1 | Commit is retiring up to commit_seq |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Start a squash |
| squash_seq | input | SEQ_W | Loads younger than this are removed |
| squash_busy | output | 1 | Squash walk in progress |
| count | output | CNT_W | Number of loads held |
| head_seq | output | SEQ_W | Sequence number of the oldest load |
| head_sq_vld | output | 1 | Oldest load recorded a store position |
| head_sq_pos | output | SQ_IDX_W | Store position of the oldest load |

## Verification
The assertions assume several things about the inputs. Sequence numbers rise in allocation order and never wrap while loads are held. `exec_idx` names a slot that holds a load. `st_lq_pos` lies between head and tail. Squash, store checks and allocations are not started while a squash walk runs. The bench keeps to these rules by construction. It draws sequence steps from a small positive range and executes only occupied slots. It picks store positions as offsets from the modelled head, and it waits for each scan or squash to finish before the next operation.

// File: rtl/lqc_pkg.sv
package lqc_pkg;
    typedef enum logic [1:0] {
        LQ_IDLE   = 2'd0,
        LQ_SCAN   = 2'd1,
        LQ_SQUASH = 2'd2
    } lq_mode_e;
endpackage

// File: rtl/lqc_addr_match.sv
module lqc_addr_match #(
    parameter int ADDR_W = 32,
    parameter int SHIFT  = 8
) (
    input  logic              ld_vld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              hit
);
    // Coarse region compare: only bits above SHIFT take part.
    always_comb begin
        hit = ld_vld && ((ld_addr >> SHIFT) == (st_addr >> SHIFT));
    end
endmodule

// File: rtl/lqc_entries.sv
module lqc_entries #(
    parameter int SLOTS    = 8,
    parameter int IDX_W    = 3,
    parameter int SEQ_W    = 16,
    parameter int ADDR_W   = 32,
    parameter int SQ_IDX_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_we,
    input  logic [IDX_W-1:0]    alloc_slot,
    input  logic [SEQ_W-1:0]    alloc_seq,
    input  logic                alloc_sqv,
    input  logic [SQ_IDX_W-1:0] alloc_sqp,
    input  logic                exec_we,
    input  logic [IDX_W-1:0]    exec_slot,
    input  logic [ADDR_W-1:0]   exec_addr,
    output logic [SEQ_W-1:0]    seq_o  [SLOTS],
    output logic                sqv_o  [SLOTS],
    output logic [SQ_IDX_W-1:0] sqp_o  [SLOTS],
    output logic                av_o   [SLOTS],
    output logic [ADDR_W-1:0]   addr_o [SLOTS]
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [SEQ_W-1:0]    seq_d,  seq_q;
        logic                sqv_d,  sqv_q;
        logic [SQ_IDX_W-1:0] sqp_d,  sqp_q;
        logic                av_d,   av_q;
        logic [ADDR_W-1:0]   addr_d, addr_q;

        always_comb begin
            seq_d  = seq_q;
            sqv_d  = sqv_q;
            sqp_d  = sqp_q;
            av_d   = av_q;
            addr_d = addr_q;
            if (alloc_we && alloc_slot == IDX_W'(s)) begin
                seq_d  = alloc_seq;
                sqv_d  = alloc_sqv;
                sqp_d  = alloc_sqp;
                av_d   = 1'b0;
                addr_d = '0;
            end else if (exec_we && exec_slot == IDX_W'(s)) begin
                av_d   = 1'b1;
                addr_d = exec_addr;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seq_q  <= '0;
                sqv_q  <= 1'b0;
                sqp_q  <= '0;
                av_q   <= 1'b0;
                addr_q <= '0;
            end else begin
                seq_q  <= seq_d;
                sqv_q  <= sqv_d;
                sqp_q  <= sqp_d;
                av_q   <= av_d;
                addr_q <= addr_d;
            end
        end

        assign seq_o[s]  = seq_q;
        assign sqv_o[s]  = sqv_q;
        assign sqp_o[s]  = sqp_q;
        assign av_o[s]   = av_q;
        assign addr_o[s] = addr_q;
    end
endmodule

// File: rtl/lq_order_check.sv
module lq_order_check #(
    parameter int DEPTH       = 7,
    parameter int SEQ_W       = 16,
    parameter int ADDR_W      = 32,
    parameter int SQ_IDX_W    = 3,
    parameter int MATCH_SHIFT = 8,
    localparam int SLOTS      = DEPTH + 1,
    localparam int IDX_W      = $clog2(SLOTS),
    localparam int CNT_W      = $clog2(SLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [SEQ_W-1:0]    alloc_seq,
    input  logic [SQ_IDX_W-1:0] sq_tail,
    input  logic                sq_empty,
    output logic                alloc_ready,
    output logic [IDX_W-1:0]    alloc_idx,
    input  logic                exec_valid,
    input  logic [IDX_W-1:0]    exec_idx,
    input  logic [ADDR_W-1:0]   exec_addr,
    input  logic                st_valid,
    input  logic [IDX_W-1:0]    st_lq_pos,
    input  logic [ADDR_W-1:0]   st_addr,
    output logic                st_busy,
    output logic                viol_pulse,
    output logic [IDX_W-1:0]    viol_idx,
    output logic                viol_hold,
    input  logic                viol_ack,
    input  logic                commit_valid,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_valid,
    input  logic [SEQ_W-1:0]    squash_seq,
    output logic                squash_busy,
    output logic [CNT_W-1:0]    count,
    output logic [SEQ_W-1:0]    head_seq,
    output logic                head_sq_vld,
    output logic [SQ_IDX_W-1:0] head_sq_pos
);
    import lqc_pkg::*;

    typedef struct packed {
        lq_mode_e          mode;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tail;
        logic [IDX_W-1:0]  ptr;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] st_addr;
        logic [SEQ_W-1:0]  cut_seq;
        logic              hold;
        logic [IDX_W-1:0]  vidx;
        logic              pulse;
    } ctl_t;

    ctl_t q, d;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] x);
        return (x == IDX_W'(SLOTS - 1)) ? '0 : x + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] wrap_dec(input logic [IDX_W-1:0] x);
        return (x == '0) ? IDX_W'(SLOTS - 1) : x - 1'b1;
    endfunction

    logic [SEQ_W-1:0]    seq_w  [SLOTS];
    logic                sqv_w  [SLOTS];
    logic [SQ_IDX_W-1:0] sqp_w  [SLOTS];
    logic                av_w   [SLOTS];
    logic [ADDR_W-1:0]   addr_w [SLOTS];

    logic do_alloc, do_retire, do_remove, scan_hit;
    logic [IDX_W-1:0] youngest;

    assign youngest    = wrap_dec(q.tail);
    assign alloc_ready = (q.cnt != CNT_W'(DEPTH)) && (q.mode != LQ_SQUASH);
    assign do_alloc    = alloc_valid && alloc_ready;

    lqc_entries #(
        .SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W),
        .ADDR_W(ADDR_W), .SQ_IDX_W(SQ_IDX_W)
    ) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_we   (do_alloc),
        .alloc_slot (q.tail),
        .alloc_seq  (alloc_seq),
        .alloc_sqv  (!sq_empty),
        .alloc_sqp  (sq_tail),
        .exec_we    (exec_valid),
        .exec_slot  (exec_idx),
        .exec_addr  (exec_addr),
        .seq_o      (seq_w),
        .sqv_o      (sqv_w),
        .sqp_o      (sqp_w),
        .av_o       (av_w),
        .addr_o     (addr_w)
    );

    lqc_addr_match #(.ADDR_W(ADDR_W), .SHIFT(MATCH_SHIFT)) u_match (
        .ld_vld  (av_w[q.ptr]),
        .ld_addr (addr_w[q.ptr]),
        .st_addr (q.st_addr),
        .hit     (scan_hit)
    );

    always_comb begin
        d         = q;
        d.pulse   = 1'b0;
        do_remove = 1'b0;
        do_retire = commit_valid && (q.mode != LQ_SQUASH) && (q.cnt != '0)
                    && (seq_w[q.head] <= commit_seq);
        if (viol_ack) d.hold = 1'b0;

        case (q.mode)
            LQ_IDLE: begin
                if (squash_valid) begin
                    d.mode    = LQ_SQUASH;
                    d.cut_seq = squash_seq;
                end else if (st_valid && !q.hold && st_lq_pos != q.tail) begin
                    d.mode    = LQ_SCAN;
                    d.ptr     = st_lq_pos;
                    d.st_addr = st_addr;
                end
            end
            LQ_SCAN: begin
                if (squash_valid) begin
                    d.mode    = LQ_SQUASH;
                    d.cut_seq = squash_seq;
                end else if (q.ptr == q.tail) begin
                    d.mode = LQ_IDLE;
                end else if (scan_hit) begin
                    d.hold  = 1'b1;
                    d.vidx  = q.ptr;
                    d.pulse = 1'b1;
                    d.mode  = LQ_IDLE;
                end else begin
                    d.ptr = wrap_inc(q.ptr);
                end
            end
            default: begin
                if (q.cnt != '0 && seq_w[youngest] > q.cut_seq) begin
                    do_remove = 1'b1;
                    d.tail    = youngest;
                end else begin
                    d.mode = LQ_IDLE;
                end
            end
        endcase

        if (do_alloc)  d.tail = wrap_inc(q.tail);
        if (do_retire) d.head = wrap_inc(q.head);
        d.cnt = q.cnt + CNT_W'(do_alloc) - CNT_W'(do_retire) - CNT_W'(do_remove);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= LQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign alloc_idx   = q.tail;
    assign st_busy     = (q.mode == LQ_SCAN);
    assign squash_busy = (q.mode == LQ_SQUASH);
    assign viol_pulse  = q.pulse;
    assign viol_idx    = q.vidx;
    assign viol_hold   = q.hold;
    assign count       = q.cnt;
    assign head_seq    = seq_w[q.head];
    assign head_sq_vld = sqv_w[q.head];
    assign head_sq_pos = sqp_w[q.head];

    // R2: occupancy never exceeds the usable capacity
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DEPTH));

    // R2: ring distance between pointers agrees with the occupancy counter
    a_r2_ptr_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(q.tail) + SLOTS - 32'(q.head)) % SLOTS) == 32'(q.cnt));

    // R6: a violation report only ends a running scan
    a_r6_pulse_from_scan: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> ($past(q.mode) == LQ_SCAN) && !st_busy);

    // R7: a latched violator is held until acknowledged
    a_r7_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_hold && !viol_ack) |=> (viol_hold && $stable(viol_idx)));

    // R8: occupancy shrinks outside a squash only when commit asked for it
    a_r8_retire_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode != LQ_SQUASH && !commit_valid) |=> (q.cnt >= $past(q.cnt)));

    // R9: a squash walk never grows the queue
    a_r9_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        squash_busy |=> (q.cnt <= $past(q.cnt)));
endmodule

// File: tb/lq_order_check_tb.sv
module lq_order_check_tb;
    localparam int DEPTH = 7;
    localparam int SLOTS = DEPTH + 1;
    localparam int IDX_W = 3;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, sq_empty = 0, exec_valid = 0, st_valid = 0;
    logic viol_ack = 0, commit_valid = 0, squash_valid = 0;
    logic [15:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
    logic [2:0]  sq_tail = 0;
    logic [IDX_W-1:0] exec_idx = 0, st_lq_pos = 0;
    logic [31:0] exec_addr = 0, st_addr = 0;
    logic alloc_ready, st_busy, viol_pulse, viol_hold, squash_busy, head_sq_vld;
    logic [IDX_W-1:0] alloc_idx, viol_idx;
    logic [CNT_W-1:0] count;
    logic [15:0] head_seq;
    logic [2:0]  head_sq_pos;

    always #2 clk = ~clk;

    lq_order_check u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .sq_tail(sq_tail),
        .sq_empty(sq_empty), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
        .st_valid(st_valid), .st_lq_pos(st_lq_pos), .st_addr(st_addr),
        .st_busy(st_busy), .viol_pulse(viol_pulse), .viol_idx(viol_idx),
        .viol_hold(viol_hold), .viol_ack(viol_ack),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .squash_busy(squash_busy), .count(count), .head_seq(head_seq),
        .head_sq_vld(head_sq_vld), .head_sq_pos(head_sq_pos)
    );

    int total = 0, bad = 0;

    // bench model
    logic [15:0] m_seq [SLOTS];
    logic        m_sqv [SLOTS];
    logic [2:0]  m_sqp [SLOTS];
    logic        m_av  [SLOTS];
    logic [31:0] m_addr[SLOTS];
    int m_head = 0, m_tail = 0, m_cnt = 0;
    logic m_hold = 0;
    int m_vidx = 0;
    logic [15:0] next_seq = 16'd100;

    function automatic int winc(int x); return (x + 1) % SLOTS; endfunction
    function automatic int wdec(int x); return (x + SLOTS - 1) % SLOTS; endfunction
    function automatic bit region_eq(logic [31:0] a, logic [31:0] b);
        return (a >> 8) == (b >> 8);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_alloc(logic [15:0] s, logic emp, logic [2:0] sqp);
        bit exp_rdy = (m_cnt < DEPTH);
        chk(alloc_ready == exp_rdy, "R2 alloc_ready", alloc_ready, exp_rdy);
        chk(alloc_idx == IDX_W'(m_tail), "R2 alloc_idx", alloc_idx, m_tail);
        alloc_valid = 1; alloc_seq = s; sq_empty = emp; sq_tail = sqp;
        @(negedge clk);
        alloc_valid = 0;
        if (exp_rdy) begin
            m_seq[m_tail] = s; m_sqv[m_tail] = !emp; m_sqp[m_tail] = sqp;
            m_av[m_tail] = 0; m_addr[m_tail] = 0;
            m_tail = winc(m_tail); m_cnt++;
        end
        chk(count == CNT_W'(m_cnt), "R2 count after alloc", count, m_cnt);
    endtask

    task automatic do_exec(int idx, logic [31:0] a);
        exec_valid = 1; exec_idx = IDX_W'(idx); exec_addr = a;
        @(negedge clk);
        exec_valid = 0;
        m_av[idx] = 1; m_addr[idx] = a;
    endtask

    task automatic do_store(int pos, logic [31:0] a);
        int exp_busy = 0, exp_hit = -1, busy_n = 0, pulse_n = 0, got_idx = -1;
        if (!m_hold) begin
            int p = pos;
            while (p != m_tail) begin
                if (m_av[p] && region_eq(m_addr[p], a)) begin exp_hit = p; break; end
                p = winc(p); exp_busy++;
            end
            if (pos != m_tail) exp_busy = exp_busy + 1;
        end
        st_valid = 1; st_lq_pos = IDX_W'(pos); st_addr = a;
        @(negedge clk);
        st_valid = 0;
        for (int i = 0; i < 40; i++) begin
            if (viol_pulse) begin pulse_n++; got_idx = viol_idx; end
            if (!st_busy) break;
            busy_n++;
            @(negedge clk);
        end
        chk(busy_n == exp_busy, "R4 scan cycles", busy_n, exp_busy);
        chk(pulse_n == (exp_hit >= 0 ? 1 : 0), "R6 pulse count", pulse_n, exp_hit >= 0);
        if (exp_hit >= 0) begin
            chk(got_idx == exp_hit, "R6 violator index", got_idx, exp_hit);
            m_hold = 1; m_vidx = exp_hit;
        end
        chk(viol_hold == m_hold, "R7 hold", viol_hold, m_hold);
        if (m_hold) chk(viol_idx == IDX_W'(m_vidx), "R7 held index", viol_idx, m_vidx);
    endtask

    task automatic do_ack();
        viol_ack = 1;
        @(negedge clk);
        viol_ack = 0;
        m_hold = 0;
        chk(viol_hold == 0, "R7 ack clears", viol_hold, 0);
    endtask

    task automatic do_commit(logic [15:0] cs);
        commit_valid = 1; commit_seq = cs;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (m_cnt > 0 && m_seq[m_head] <= cs) begin m_head = winc(m_head); m_cnt--; end
        end
        commit_valid = 0;
        chk(count == CNT_W'(m_cnt), "R8 count after commit", count, m_cnt);
        if (m_cnt > 0) begin
            chk(head_seq == m_seq[m_head], "R8 head_seq", head_seq, m_seq[m_head]);
            chk(head_sq_vld == m_sqv[m_head], "R3 head_sq_vld", head_sq_vld, m_sqv[m_head]);
            if (m_sqv[m_head])
                chk(head_sq_pos == m_sqp[m_head], "R3 head_sq_pos", head_sq_pos, m_sqp[m_head]);
        end
    endtask

    task automatic do_squash(logic [15:0] ss);
        int removed = 0, busy_n = 0;
        bit rdy_ok = 1;
        while (m_cnt > 0 && m_seq[wdec(m_tail)] > ss) begin
            m_tail = wdec(m_tail); m_cnt--; removed++;
        end
        squash_valid = 1; squash_seq = ss;
        @(negedge clk);
        squash_valid = 0;
        for (int i = 0; i < 40; i++) begin
            if (!squash_busy) break;
            if (alloc_ready) rdy_ok = 0;
            busy_n++;
            @(negedge clk);
        end
        chk(busy_n == removed + 1, "R9 squash cycles", busy_n, removed + 1);
        chk(rdy_ok, "R9 alloc blocked in squash", rdy_ok, 1);
        chk(count == CNT_W'(m_cnt), "R9 count after squash", count, m_cnt);
        chk(alloc_idx == IDX_W'(m_tail), "R9 tail after squash", alloc_idx, m_tail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < SLOTS; i++) begin
            m_seq[i] = 0; m_sqv[i] = 0; m_sqp[i] = 0; m_av[i] = 0; m_addr[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(count == 0, "R1 count", count, 0);
        chk(alloc_ready == 1, "R1 alloc_ready", alloc_ready, 1);
        chk(!st_busy && !squash_busy, "R1 busy", {st_busy, squash_busy}, 0);
        chk(!viol_hold && !viol_pulse, "R1 violator", {viol_hold, viol_pulse}, 0);

        // R2/R3: fill to capacity, first load with empty store queue
        for (int i = 0; i < DEPTH; i++) do_alloc(16'(10 + i), i == 0, 3'd5);
        chk(alloc_ready == 0, "R2 full", alloc_ready, 0);
        do_alloc(16'd99, 0, 3'd1);   // R2 ignored when full
        chk(head_sq_vld == 0, "R3 empty store queue", head_sq_vld, 0);

        // R5/R6: slots 3 and 5 share region 0x13; slot 6 left unexecuted
        for (int i = 0; i < 6; i++) do_exec(i, 32'h1000 + 32'(i) * 32'h100);
        do_exec(3, 32'h1340);
        do_exec(5, 32'h13FF);
        do_store(1, 32'h1300);       // R6 first hit slot 3, R4 three cycles
        do_store(0, 32'h1000);       // R7 ignored while held
        do_ack();
        do_store(0, 32'h0000_0010);  // R5 unexecuted slot 6 (addr 0) not a hit
        do_store(0, 32'h2000);       // R4 full scan, no hit
        do_store(m_tail, 32'h1300);  // R4 empty range

        // R8 commit and R3 store position at head
        do_commit(16'd12);
        chk(count == 4, "R8 three retired", count, 4);
        do_commit(16'd5);
        // R9 squash
        do_squash(16'd14);
        chk(count == 2, "R9 two removed", count, 2);
        // R2 wrap-around allocations
        for (int i = 0; i < 5; i++) do_alloc(next_seq + 16'(i), 0, 3'(i));
        next_seq = next_seq + 16'd10;

        // constrained random mix
        for (int it = 0; it < 600; it++) begin
            int op = $urandom % 10;
            if (op < 4) begin
                do_alloc(next_seq, ($urandom % 3) == 0, 3'($urandom));
                next_seq = next_seq + 16'(1 + $urandom % 3);
            end else if (op < 6) begin
                if (m_cnt > 0)
                    do_exec((m_head + $urandom % m_cnt) % SLOTS,
                            {22'd0, 2'($urandom), 8'($urandom)});
            end else if (op < 8) begin
                int off = (m_cnt > 0) ? $urandom % (m_cnt + 1) : 0;
                do_store((m_head + off) % SLOTS, {22'd0, 2'($urandom), 8'($urandom)});
                if (m_hold && ($urandom % 2)) do_ack();
            end else if (op == 8) begin
                if (m_cnt > 0) do_commit(m_seq[m_head] + 16'($urandom % 6));
                else do_commit(16'($urandom % 50));
            end else begin
                if (m_cnt > 0) do_squash(m_seq[(m_head + $urandom % m_cnt) % SLOTS] - 16'($urandom % 2));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule